// File: doc/BRIEF.md
# AES Inverse Column Mixer, Two-Stage Pipeline

This block applies the AES inverse column-mixing step to one 32-bit state column. It computes each output byte as a GF(2^8) product of the input column and the circulant matrix whose first row is {0e, 0b, 0d, 09}, with reduction modulo x^8+x^4+x^3+x+1. It sits in the decryption datapath of a round engine. A new column can be offered on every clock, and each result appears exactly two cycles after its column was accepted.

The work is split over two register stages. The first stage forms the forward-mix term of every output byte. It also forms two shared pair sums: the bytewise XOR of bytes 0 and 2, and the bytewise XOR of bytes 1 and 3. The second stage finishes each byte from these registered values. It adds four times the pair sum that belongs to the row's parity, and eight times the XOR of both pair sums. No separate multipliers for {09}, {0b}, {0d} or {0e} exist. A valid flag travels alongside the data. The data registers load only when that flag is set, so the last result is held between columns.

Top module: `inv_mixcol_pipe`

## Requirements
- R1: Byte 0 of a column is bits [31:24] and byte 3 is bits [7:0]. The same byte order applies to the input and to the result.
- R2: Result byte r equals the XOR over c of gf_mul(k[(c - r) mod 4], byte c), with k = {0e, 0b, 0d, 09} and the reduction polynomial 0x11B.
- R3: res_valid_o is high in the cycle after the second rising edge following a rising edge at which col_valid_i was sampled high. It is low two edges after col_valid_i was sampled low.
- R4: While rst_ni is low, res_valid_o is low. A column that is in flight when reset arrives never produces a valid result.
- R5: Columns offered on consecutive cycles each produce their own result, on consecutive cycles and with no gap.
- R6: Feeding the forward column mix of any column X returns X.
- R7: Input column 8e4da1bc gives result db135345.
- R8: When no column was accepted two edges earlier, res_o keeps its previous value.
- R9: Data on col_i while col_valid_i is low has no effect on res_valid_o or res_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset for the valid flags |
| col_valid_i | input | 1 | Column on col_i is to be processed |
| col_i | input | 32 | Input column, byte 0 in the top bits |
| res_valid_o | output | 1 | res_o holds a new result this cycle |
| res_o | output | 32 | Inverse-mixed column, byte 0 in the top bits |

## Verification
Two functions of this block can be active in the same cycle. Stage one captures a new column while stage two finishes the column before it. The bench provokes this by streaming columns on consecutive clocks, each with different data: table vectors, random round-trip columns, and random direct columns. Every output slot is judged against the value expected for its own column. A stale or shifted stage-one register would therefore show up as a mismatch. A reset asserted while a column is between the stages checks the second overlap, where reset clearing and result emission coincide.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_ROWS = 4;
  localparam int unsigned COL_W  = BYTE_W * N_ROWS;
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1b;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [COL_W-1:0]  col_t;

  function automatic byte_t xt(byte_t b);
    return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? RED_POLY : '0);
  endfunction

  function automatic byte_t mul3(byte_t b);
    return xt(b) ^ b;
  endfunction

  function automatic byte_t mul4(byte_t b);
    return xt(xt(b));
  endfunction

  function automatic byte_t mul8(byte_t b);
    return xt(xt(xt(b)));
  endfunction

  // generic shift-and-add product, used only by checking logic
  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xt(sh);
    end
    return acc;
  endfunction
endpackage

// File: rtl/imc_vld_dly.sv
module imc_vld_dly #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  output logic [DEPTH-1:0] tap_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_tap
    logic nxt;
    if (s == 0) begin : g_head
      assign nxt = vld_i;
    end else begin : g_body
      assign nxt = tap_o[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_o[s] <= 1'b0;
      else         tap_o[s] <= nxt;
    end
  end
endmodule

// File: rtl/imc_fold.sv
// Stage one: forward-mix term per row plus the two shared pair sums.
module imc_fold
  import imc_pkg::*;
(
  input  logic  clk_i,
  input  logic  en_i,
  input  col_t  col_i,
  output col_t  fwd_o,
  output byte_t pair_even_o,
  output byte_t pair_odd_o
);
  byte_t e [N_ROWS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    byte_t fwd_d;
    assign e[r]  = col_i[COL_W-1-r*BYTE_W -: BYTE_W];
    assign fwd_d = xt(e[r]) ^ mul3(e[(r+1)%N_ROWS])
                 ^ e[(r+2)%N_ROWS] ^ e[(r+3)%N_ROWS];
    always_ff @(posedge clk_i) begin
      if (en_i) fwd_o[COL_W-1-r*BYTE_W -: BYTE_W] <= fwd_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      pair_even_o <= e[0] ^ e[2];
      pair_odd_o  <= e[1] ^ e[3];
    end
  end
endmodule

// File: rtl/imc_merge.sv
// Stage two: fold shared pair sums into each row's forward term.
module imc_merge
  import imc_pkg::*;
(
  input  logic  clk_i,
  input  logic  en_i,
  input  col_t  fwd_i,
  input  byte_t pair_even_i,
  input  byte_t pair_odd_i,
  output col_t  res_o
);
  byte_t all_x8;
  assign all_x8 = mul8(pair_even_i ^ pair_odd_i);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    byte_t own_x4;
    byte_t res_d;
    if (r % 2 == 0) begin : g_even
      assign own_x4 = mul4(pair_even_i);
    end else begin : g_odd
      assign own_x4 = mul4(pair_odd_i);
    end
    assign res_d = fwd_i[COL_W-1-r*BYTE_W -: BYTE_W] ^ own_x4 ^ all_x8;
    always_ff @(posedge clk_i) begin
      if (en_i) res_o[COL_W-1-r*BYTE_W -: BYTE_W] <= res_d;
    end
  end
endmodule

// File: rtl/inv_mixcol_pipe.sv
module inv_mixcol_pipe
  import imc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        col_valid_i,
  input  logic [31:0] col_i,
  output logic        res_valid_o,
  output logic [31:0] res_o
);
  localparam int unsigned STAGES = 2;

  logic [STAGES-1:0] vld_q;
  col_t              fwd_q;
  byte_t             pe_q;
  byte_t             po_q;

  imc_vld_dly #(.DEPTH(STAGES)) u_vld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (col_valid_i),
    .tap_o  (vld_q)
  );

  imc_fold u_fold (
    .clk_i       (clk_i),
    .en_i        (col_valid_i),
    .col_i       (col_i),
    .fwd_o       (fwd_q),
    .pair_even_o (pe_q),
    .pair_odd_o  (po_q)
  );

  imc_merge u_merge (
    .clk_i       (clk_i),
    .en_i        (vld_q[0]),
    .fwd_i       (fwd_q),
    .pair_even_i (pe_q),
    .pair_odd_i  (po_q),
    .res_o       (res_o)
  );

  assign res_valid_o = vld_q[STAGES-1];
endmodule

// File: rtl/inv_mixcol_pipe_chk.sv
module inv_mixcol_pipe_chk
  import imc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        col_valid_i,
  input logic [31:0] col_i,
  input logic        res_valid_o,
  input logic [31:0] res_o
);
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= '0;
    else if (seen_q != 2'd3)  seen_q <= seen_q + 2'd1;
  end

  function automatic col_t ref_inv(col_t c);
    byte_t k [N_ROWS];
    col_t  r;
    k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09;
    r = '0;
    for (int row = 0; row < N_ROWS; row++) begin
      byte_t acc;
      acc = '0;
      for (int c2 = 0; c2 < N_ROWS; c2++)
        acc = acc ^ gf_mul(k[(c2 - row + N_ROWS) % N_ROWS],
                           c[COL_W-1-c2*BYTE_W -: BYTE_W]);
      r[COL_W-1-row*BYTE_W -: BYTE_W] = acc;
    end
    return r;
  endfunction

  a_r3_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2) |-> (res_valid_o == $past(col_valid_i, 2)));

  a_r2_result_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2 && res_valid_o) |-> (res_o == ref_inv($past(col_i, 2))));

  a_r5_no_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd3 && $past(col_valid_i, 2) && $past(col_valid_i, 1))
      |=> (res_valid_o && $past(res_valid_o)));

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd3 && !$past(col_valid_i, 2)) |-> $stable(res_o));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r4_reset_clear: assert (!res_valid_o);
    end
  end
endmodule

bind inv_mixcol_pipe inv_mixcol_pipe_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .col_valid_i (col_valid_i),
  .col_i       (col_i),
  .res_valid_o (res_valid_o),
  .res_o       (res_o)
);

// File: tb/inv_mixcol_pipe_tb_top.sv
`timescale 1ns/1ps
module inv_mixcol_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        col_valid_i = 1'b0;
  logic [31:0] col_i = '0;
  logic        res_valid_o;
  logic [31:0] res_o;

  int n_cmp  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  inv_mixcol_pipe dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .col_valid_i (col_valid_i),
    .col_i       (col_i),
    .res_valid_o (res_valid_o),
    .res_o       (res_o)
  );

  // {input, expected}; byte 0 in the top bits (R1)
  localparam logic [63:0] VEC [6] = '{
    {32'h8e4da1bc, 32'hdb135345},
    {32'h9fdc589d, 32'hf20a225c},
    {32'hd5d5d7d6, 32'hd4d4d4d5},
    {32'h4d7ebdf8, 32'h2d26314c},
    {32'h01010101, 32'h01010101},
    {32'hc6c6c6c6, 32'hc6c6c6c6}
  };

  function automatic logic [7:0] t2(logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= s;
      s = t2(s);
    end
    return acc;
  endfunction

  function automatic logic [31:0] circ(logic [31:0] c, logic [31:0] krow);
    logic [31:0] r = '0;
    for (int row = 0; row < 4; row++) begin
      logic [7:0] acc = 8'h00;
      for (int cc = 0; cc < 4; cc++)
        acc ^= gm(krow[31-((cc-row+4)%4)*8 -: 8], c[31-cc*8 -: 8]);
      r[31-row*8 -: 8] = acc;
    end
    return r;
  endfunction

  function automatic logic [31:0] fwd_mix(logic [31:0] c);
    return circ(c, 32'h02030101);
  endfunction

  function automatic logic [31:0] inv_mix(logic [31:0] c);
    return circ(c, 32'h0e0b0d09);
  endfunction

  logic        pv [2];
  logic [31:0] pe [2];
  string       pt [2];
  logic [31:0] last_res;
  logic        have_last = 1'b0;

  task automatic fail_msg(string tag, logic [31:0] act, logic [31:0] exp);
    n_fail++;
    $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic step(input logic v, input logic [31:0] d,
                      input logic [31:0] e, input string tag);
    @(negedge clk);
    n_cmp++;
    if (res_valid_o !== pv[1]) fail_msg({pt[1], " R3 valid"}, {31'd0, res_valid_o}, {31'd0, pv[1]});
    if (pv[1]) begin
      n_cmp++;
      if (res_o !== pe[1]) fail_msg(pt[1], res_o, pe[1]);
      last_res  = pe[1];
      have_last = 1'b1;
    end else if (have_last) begin
      n_cmp++;
      if (res_o !== last_res) fail_msg("R8/R9 hold", res_o, last_res);
    end
    pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
    pv[0] = v;     pe[0] = e;     pt[0] = tag;
    col_valid_i = v;
    col_i       = d;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(1'b0, 32'hdeadbeef, '0, "R9 idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    pv[0] = 1'b0; pv[1] = 1'b0;
    pe[0] = '0;   pe[1] = '0;
    pt[0] = "";   pt[1] = "";
    // R4: reset state
    repeat (3) begin
      @(negedge clk);
      n_cmp++;
      if (res_valid_o !== 1'b0) fail_msg("R4 reset", {31'd0, res_valid_o}, 32'd0);
    end
    rst_ni = 1'b1;

    // table, streamed back-to-back (R1, R2, R5, R7)
    for (int i = 0; i < 6; i++)
      step(1'b1, VEC[i][63:32], VEC[i][31:0], i == 0 ? "R7 vector" : "R2 table");
    flush();

    // round trip on random columns, no gaps (R6, R5)
    for (int i = 0; i < 40; i++) begin
      logic [31:0] x = $urandom;
      step(1'b1, fwd_mix(x), x, "R6 roundtrip");
    end
    flush();

    // random columns with gaps; junk data while idle (R2, R8, R9)
    for (int i = 0; i < 60; i++) begin
      logic [31:0] x = $urandom;
      if ($urandom % 3 == 0) step(1'b0, x, '0, "R9 idle");
      else                   step(1'b1, x, inv_mix(x), "R2 random");
    end
    flush();

    // corner columns (R2)
    step(1'b1, 32'hffffffff, inv_mix(32'hffffffff), "R2 all ones");
    step(1'b1, 32'h80000000, inv_mix(32'h80000000), "R2 top bit");
    step(1'b1, 32'h00000001, inv_mix(32'h00000001), "R2 low bit");
    step(1'b1, 32'h00000000, 32'h00000000, "R2 zero");
    flush();

    // R4: reset while a column sits between the stages
    step(1'b1, 32'h12345678, inv_mix(32'h12345678), "R4 inflight");
    @(negedge clk);
    rst_ni = 1'b0;
    col_valid_i = 1'b0;
    #1;
    n_cmp++;
    if (res_valid_o !== 1'b0) fail_msg("R4 async clear", {31'd0, res_valid_o}, 32'd0);
    @(negedge clk);
    n_cmp++;
    if (res_valid_o !== 1'b0) fail_msg("R4 held", {31'd0, res_valid_o}, 32'd0);
    rst_ni = 1'b1;
    pv[0] = 1'b0; pv[1] = 1'b0;
    flush();

    // R7 again after reset, single column
    step(1'b1, 32'h8e4da1bc, 32'hdb135345, "R7 after reset");
    flush();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule